// File: doc/BRIEF.md
# Selectable Line Tone Generator

This block produces the logic-level modulation tone that an analog wave shaper superimposes on a DC supply line. A free-running prescaler turns the system clock into a switching-rate tick, and a phase counter divides that tick by a fixed ratio to form a square tone with equal high and low halves. With the default ratio of 16, a 352 kHz tick gives a 22 kHz tone.

Two control bits and one external modulation pin choose the tone source and its gate. The two bits are `tone_internal_i` and `tone_gate_i`.

- Both bits high: the internal tone runs continuously.
- Internal set, gate clear: the internal tone runs while the synchronized pin is high.
- Internal clear, gate clear: the tone is off.
- Internal clear, gate set: the pin level goes straight to the output. It keeps toggling or holding at whatever level the pin has.

The internal tone is switched on and off only at the end of a full tone period, so a gate change never produces a short pulse. The output is a pair of signals. `tone_active_o` tells the shaper to apply the tone offset. `tone_level_o` then chooses the plus-half level (1) or the minus-half level (0). When the tone is inactive, the level rests at 0 and the line sits at its DC set point.

Top module: `lnb_tone_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `sw_tick_o`, `tone_active_o` and `tone_level_o` are all 0.
- R2: `sw_tick_o` is a single-cycle pulse that occurs exactly once every SW_DIV clock cycles.
- R3: The internal tone has a period of SW_DIV*TONE_DIV clock cycles. It is high for exactly half of that period and low for the other half.
- R4: With `tone_internal_i`=1 and `tone_gate_i`=1, `tone_active_o` stays 1 and `tone_level_o` carries the internal tone.
- R5: With `tone_internal_i`=1 and `tone_gate_i`=0, the internal tone is output while the synchronized `extm_i` is 1. It is off, with `tone_active_o`=0, while `extm_i` is 0.
- R6: In the internal modes, the internal tone starts and stops only at a tone period boundary. Every high pulse on `tone_level_o` therefore lasts exactly half a period, and every active interval is a whole number of periods.
- R7: With `tone_internal_i`=0 and `tone_gate_i`=0, `tone_active_o` stays 0 whatever `extm_i` does.
- R8: With `tone_internal_i`=0 and `tone_gate_i`=1, `tone_active_o` is 1 and `tone_level_o` follows `extm_i`. A pin held low holds the output at level 0 (minus half), and a pin held high holds it at level 1 (plus half).
- R9: Whenever `tone_active_o` is 0, `tone_level_o` is 0 (mid level).
- R10: `extm_i` passes through SYNC_STAGES synchronizing flops and one output register. A pin change therefore reaches `tone_level_o` after SYNC_STAGES+1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_internal_i | input | 1 | 1 selects the internal tone, 0 selects the external pin |
| tone_gate_i | input | 1 | Tone gate bit; its meaning depends on the source mode |
| extm_i | input | 1 | Asynchronous external modulation pin |
| sw_tick_o | output | 1 | Switching-rate enable pulse |
| tone_active_o | output | 1 | 1 = apply the tone offset to the line |
| tone_level_o | output | 1 | Tone half when active: 1 = plus, 0 = minus |

## Verification
The bench builds the block with SW_DIV=4, TONE_DIV=16 and SYNC_STAGES=2. With these values a tone period is 64 cycles and a half period is 32 cycles, so several whole periods fit in a few hundred cycles. Pin gating can then be toggled at offsets that fall in the middle of a period, which tests the boundary-only gating. The short synchronizer makes the pass-through latency small enough to check edge by edge.

// File: rtl/lnb_tone_pkg.sv
package lnb_tone_pkg;

  typedef enum logic [1:0] {
    SRC_OFF      = 2'b00,
    SRC_PIN_RAW  = 2'b01,
    SRC_INT_PIN  = 2'b10,
    SRC_INT_BIT  = 2'b11
  } tone_src_e;

  function automatic tone_src_e decode_src(input logic use_int, input logic gate_bit);
    return tone_src_e'({use_int, gate_bit});
  endfunction

endpackage

// File: rtl/lnb_tone_sync.sv
module lnb_tone_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/lnb_tone_divider.sv
module lnb_tone_divider #(
  parameter int SW_DIV   = 4,
  parameter int TONE_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic sw_tick_o,
  output logic wrap_o,
  output logic tone_hi_o
);

  localparam int PW = (SW_DIV > 1) ? $clog2(SW_DIV) : 1;
  localparam int TW = $clog2(TONE_DIV);
  localparam int HALF = TONE_DIV / 2;

  logic [PW-1:0] pre_q;
  logic          tick_q;
  logic [TW-1:0] phase_q;

  // Prescaler: one tick every SW_DIV clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (pre_q == PW'(SW_DIV - 1));
      if (pre_q == PW'(SW_DIV - 1)) pre_q <= '0;
      else                          pre_q <= pre_q + 1'b1;
    end
  end

  // Tone phase counter advanced by the switching tick
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (tick_q) begin
      if (phase_q == TW'(TONE_DIV - 1)) phase_q <= '0;
      else                              phase_q <= phase_q + 1'b1;
    end
  end

  assign sw_tick_o = tick_q;
  assign wrap_o    = tick_q && (phase_q == TW'(TONE_DIV - 1));
  assign tone_hi_o = (phase_q < TW'(HALF));

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sw_tick_o |=> !sw_tick_o) else $error("tick longer than one cycle"); // R2

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase_q <= TW'(TONE_DIV - 1)) else $error("phase out of range"); // R3

endmodule

// File: rtl/lnb_tone_select.sv
module lnb_tone_select
  import lnb_tone_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic use_int_i,
  input  logic gate_bit_i,
  input  logic pin_i,
  input  logic wrap_i,
  input  logic tone_hi_i,
  output logic active_o,
  output logic level_o
);

  tone_src_e src;
  logic      int_req;
  logic      int_en_q;
  logic      act_d, lvl_d;
  logic      active_q, level_q;

  assign src = decode_src(use_int_i, gate_bit_i);

  always_comb begin
    unique case (src)
      SRC_INT_BIT: int_req = 1'b1;
      SRC_INT_PIN: int_req = pin_i;
      default:     int_req = 1'b0;
    endcase
  end

  // Internal gate only moves at a period boundary
  always_ff @(posedge clk) begin
    if (rst)         int_en_q <= 1'b0;
    else if (wrap_i) int_en_q <= int_req;
  end

  always_comb begin
    unique case (src)
      SRC_INT_BIT, SRC_INT_PIN: begin
        act_d = int_en_q;
        lvl_d = int_en_q & tone_hi_i;
      end
      SRC_PIN_RAW: begin
        act_d = 1'b1;
        lvl_d = pin_i;
      end
      default: begin
        act_d = 1'b0;
        lvl_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      level_q  <= 1'b0;
    end else begin
      active_q <= act_d;
      level_q  <= lvl_d;
    end
  end

  assign active_o = active_q;
  assign level_o  = level_q;

  AST_IDLE_MID: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> !level_o) else $error("level set while idle"); // R9

  AST_GATE_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$stable(int_en_q) |-> $past(wrap_i)) else $error("gate moved mid-period"); // R6

  AST_EXT_OFF: assert property (@(posedge clk) disable iff (rst)
    (!use_int_i && !gate_bit_i) |=> !active_o) else $error("tone on while off"); // R7

  AST_RAW_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!use_int_i && gate_bit_i) |=> (active_o && level_o == $past(pin_i))) else $error("pass-through mismatch"); // R8

endmodule

// File: rtl/lnb_tone_gen.sv
module lnb_tone_gen #(
  parameter int SW_DIV      = 4,
  parameter int TONE_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tone_internal_i,
  input  logic tone_gate_i,
  input  logic extm_i,
  output logic sw_tick_o,
  output logic tone_active_o,
  output logic tone_level_o
);

  logic pin_s;
  logic wrap;
  logic tone_hi;

  lnb_tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (extm_i),
    .sync_o  (pin_s)
  );

  lnb_tone_divider #(.SW_DIV(SW_DIV), .TONE_DIV(TONE_DIV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .sw_tick_o (sw_tick_o),
    .wrap_o    (wrap),
    .tone_hi_o (tone_hi)
  );

  lnb_tone_select u_sel (
    .clk        (clk),
    .rst        (rst),
    .use_int_i  (tone_internal_i),
    .gate_bit_i (tone_gate_i),
    .pin_i      (pin_s),
    .wrap_i     (wrap),
    .tone_hi_i  (tone_hi),
    .active_o   (tone_active_o),
    .level_o    (tone_level_o)
  );

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
    !tone_active_o |-> !tone_level_o) else $error("idle level not mid"); // R9

endmodule

// File: tb/lnb_tone_gen_test.sv
module lnb_tone_gen_test;

  localparam int SW_DIV = 4;
  localparam int TONE_DIV = 16;
  localparam int SYNC = 2;
  localparam int PERIOD = SW_DIV * TONE_DIV;
  localparam int HALF = PERIOD / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmode = 1'b0, tgate = 1'b0, extm = 1'b0;
  logic sw_tick, act, lvl;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lnb_tone_gen #(.SW_DIV(SW_DIV), .TONE_DIV(TONE_DIV), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .tone_internal_i(tmode), .tone_gate_i(tgate),
    .extm_i(extm), .sw_tick_o(sw_tick), .tone_active_o(act), .tone_level_o(lvl)
  );

  // Window monitor sampled on the falling edge
  bit mon_en = 0;
  int n_hi, n_act, n_rise, n_tick, n_dbl, n_runt, n_bad_act, n_idle_lvl;
  int hi_run, act_run;
  bit seen_rise, seen_act_rise, prev_lvl, prev_act, prev_tick;

  task automatic mon_start();
    n_hi = 0; n_act = 0; n_rise = 0; n_tick = 0; n_dbl = 0; n_runt = 0;
    n_bad_act = 0; n_idle_lvl = 0; hi_run = 0; act_run = 0;
    seen_rise = 0; seen_act_rise = 0;
    prev_lvl = lvl; prev_act = act; prev_tick = sw_tick;
    mon_en = 1;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      n_hi  += int'(lvl);
      n_act += int'(act);
      n_tick += int'(sw_tick);
      if (sw_tick && prev_tick) n_dbl++;
      if (!act && lvl) n_idle_lvl++;
      if (lvl && !prev_lvl) begin n_rise++; seen_rise = 1; hi_run = 0; end
      if (lvl) hi_run++;
      if (!lvl && prev_lvl && seen_rise && hi_run != HALF) n_runt++;
      if (act && !prev_act) begin seen_act_rise = 1; act_run = 0; end
      if (act) act_run++;
      if (!act && prev_act && seen_act_rise && (act_run % PERIOD) != 0) n_bad_act++;
      prev_lvl = lvl; prev_act = act; prev_tick = sw_tick;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    wait_cycles(3);
    check("R1 active in reset", int'(act), 0);
    check("R1 level in reset", int'(lvl), 0);
    check("R1 tick in reset", int'(sw_tick), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle after reset", int'({sw_tick, act, lvl}), 0);
  endtask

  task automatic test_tick();
    mon_start();
    wait_cycles(400);
    mon_en = 0;
    check("R2 tick count", n_tick, 400 / SW_DIV);
    check("R2 tick width", n_dbl, 0);
  endtask

  task automatic test_int_bit();
    tmode = 1; tgate = 1;
    wait_cycles(2 * PERIOD + 3);
    mon_start();
    wait_cycles(4 * PERIOD);
    mon_en = 0;
    check("R4 active throughout", n_act, 4 * PERIOD);
    check("R3 duty high cycles", n_hi, 4 * HALF);
    check("R3 periods", n_rise, 4);
    check("R3 half-period runs", n_runt, 0);
  endtask

  task automatic test_int_pin();
    tmode = 1; tgate = 0; extm = 0;
    wait_cycles(2 * PERIOD + 3);
    mon_start();
    wait_cycles(2 * PERIOD);
    mon_en = 0;
    check("R5 pin low keeps tone off", n_act, 0);
    check("R5 pin low level", n_hi, 0);
    extm = 1;
    wait_cycles(2 * PERIOD + 3);
    mon_start();
    wait_cycles(4 * PERIOD);
    mon_en = 0;
    check("R5 pin high active", n_act, 4 * PERIOD);
    check("R5 pin high tone", n_hi, 4 * HALF);
  endtask

  task automatic test_no_runt();
    tmode = 1; tgate = 0; extm = 0;
    wait_cycles(PERIOD + 3);
    mon_start();
    extm = 1; wait_cycles(37);
    extm = 0; wait_cycles(53);
    extm = 1; wait_cycles(91);
    extm = 0; wait_cycles(20);
    extm = 1; wait_cycles(70);
    extm = 0; wait_cycles(3 * PERIOD);
    mon_en = 0;
    check("R6 no short pulses", n_runt, 0);
    check("R6 whole-period activity", n_bad_act, 0);
    check("R6 some tone emitted", int'(n_rise > 0), 1);
  endtask

  task automatic test_ext_off();
    tmode = 0; tgate = 0;
    wait_cycles(4);
    mon_start();
    for (int i = 0; i < 10; i++) begin
      extm = ~extm;
      wait_cycles(7 + i);
    end
    mon_en = 0;
    check("R7 off mode inactive", n_act, 0);
    check("R9 idle level mid", n_hi + n_idle_lvl, 0);
  endtask

  task automatic test_raw();
    tmode = 0; tgate = 1; extm = 0;
    wait_cycles(6);
    check("R8 held low active", int'(act), 1);
    check("R8 held low level", int'(lvl), 0);
    extm = 1;
    wait_cycles(SYNC);
    check("R10 level before latency", int'(lvl), 0);
    wait_cycles(1);
    check("R10 level after latency", int'(lvl), 1);
    wait_cycles(40);
    check("R8 held high level", int'({act, lvl}), 3);
    mon_start();
    for (int i = 0; i < 8; i++) begin
      extm = ~extm;
      wait_cycles(11);
    end
    mon_en = 0;
    check("R8 toggling pin active", n_act, 88);
    check("R8 toggling pin level count", n_rise, 4);
  endtask

  initial begin
    test_reset();
    test_tick();
    test_int_bit();
    test_int_pin();
    test_no_runt();
    test_ext_off();
    test_raw();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule